// File: doc/BRIEF.md
# SPI Receive Status and Overflow Logic

This block is the receive-side status logic of a serial peripheral interface (SPI) port. The shift register sits outside it and hands over three things: a strobe when the first data bit of a new transfer is captured, a strobe when a whole byte has been assembled, and that byte. The block keeps a receive data register and a receive-full flag. It also keeps an overflow flag and a mode-fault flag, and it drives one interrupt request line that serves both reception and errors.

Overflow is detected early. If the previous byte is still unread when the first bit of the next transfer is captured, the overflow flag sets at once. The byte then in flight is dropped and the unread byte stays in place. While overflow remains set, every further completed byte is lost and does not raise receive-full. Overflow can only be cleared on purpose, by a status read that sees the flag followed by a data read. A CPU that skips the status read therefore cannot clear the error by accident.

Software uses a small register port. Address 0 is the control register. Address 1 is the status register, which holds the flags and two writable enables. Address 2 is the data register. The byte inputs carry no back-pressure: a completed byte is either stored or dropped in the cycle its strobe is seen, so the shift register never has to wait.

Top module: `spi_rx_status`

## Requirements
- R1: When `cap_first_i` is high while receive-full is set, the overflow flag (status bit 5) is set from the next cycle on. It does not wait for that byte to complete.
- R2: A byte that completes after an overflow is not written to the data register. A data read returns the earlier byte.
- R3: While overflow is set, a completed byte (`byte_valid_i`) does not set receive-full (status bit 7), and the byte is lost.
- R4: A data read (address 2) clears receive-full. It leaves overflow set unless the clear sequence of R5 is in progress.
- R5: Overflow clears only through this sequence: a status read (address 1) that returns bit 5 set, then a data read.
- R6: The mode-fault flag (status bit 4) sets when `ss_conflict_i` is high, but only while mode-fault enable (status bit 2) is 1.
- R7: Mode-fault clears only through this sequence: a status read that returns bit 4 set, then a write to the control register (address 0). A control write without that status read leaves the flag set.
- R8: `irq_o` is high when (receive interrupt enable, control bit 7) AND receive-full is true, or when (error interrupt enable, status bit 6) AND (overflow OR mode-fault) is true. A single enable covers both error flags.
- R9: After reset, all flags and enables are 0 and the data register reads 0x00. In the status register only bits 6 and 2 are writable. Status bits 3, 1 and 0, control bits 6 to 0, and address 3 all read as 0.
- R10: A byte completed while overflow is clear is loaded into the data register and sets receive-full. Both are visible in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_first_i | input | 1 | Pulse: first data bit of a transfer captured |
| byte_valid_i | input | 1 | Pulse: assembled byte is complete |
| byte_data_i | input | DATA_W | Assembled byte |
| ss_conflict_i | input | 1 | Slave-select level conflicts with the configured mode |
| reg_addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_o | output | 1 | Combined receive/error interrupt request |

## Verification
The bench drives four back-to-back bytes and reads the second one late. A design that checks for overflow at the end of a byte shows no error at the third byte's first capture. A design that overwrites the data register returns the third or fourth byte instead of the second. A design that lets a blocked byte raise receive-full, or that clears overflow on a data read alone, shows wrong status bits after the late read. The mode-fault tests pulse a conflict with the enable off, and issue a control write before any status read. A flag that ignores its enable, or that clears without being armed, gives a wrong status value there.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;
  // status bit positions
  localparam int SB_RXFULL = 7;
  localparam int SB_ERRIE  = 6;
  localparam int SB_OVF    = 5;
  localparam int SB_MODF   = 4;
  localparam int SB_MODFEN = 2;
  // control bit positions
  localparam int CB_RXIE   = 7;
endpackage

// File: rtl/rxs_data_path.sv
module rxs_data_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_first_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rxfull_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] rx_data_q;
  logic rxfull_q, ovf_q, ovf_armed_q;
  logic accept, ovf_clear;

  assign accept    = byte_valid_i && !ovf_q;
  assign ovf_clear = data_rd_i && ovf_armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data_q   <= '0;
      rxfull_q    <= 1'b0;
      ovf_q       <= 1'b0;
      ovf_armed_q <= 1'b0;
    end else begin
      if (stat_rd_i && ovf_q)  ovf_armed_q <= 1'b1;
      else if (ovf_clear)      ovf_armed_q <= 1'b0;

      if (cap_first_i && rxfull_q) ovf_q <= 1'b1;
      else if (ovf_clear)          ovf_q <= 1'b0;

      if (accept) begin
        rx_data_q <= byte_data_i;
        rxfull_q  <= 1'b1;
      end else if (data_rd_i) begin
        rxfull_q  <= 1'b0;
      end
    end
  end

  assign rx_data_o = rx_data_q;
  assign rxfull_o  = rxfull_q;
  assign ovf_o     = ovf_q;

  AST_OVF_AT_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_first_i && rxfull_q) |=> ovf_q); // R1
  AST_OVF_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && byte_valid_i) |=> $stable(rx_data_q)); // R2
  AST_OVF_BLOCKS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && byte_valid_i && !rxfull_q) |=> !rxfull_q); // R3
  AST_RD_LEAVES_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_i && ovf_q && !ovf_armed_q) |=> ovf_q); // R4
  AST_FULL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && !ovf_q) |=> (rxfull_q && rx_data_q == $past(byte_data_i))); // R10
endmodule

// File: rtl/rxs_fault.sv
module rxs_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_conflict_i,
  input  logic modfen_i,
  input  logic stat_rd_i,
  input  logic ctrl_wr_i,
  output logic modf_o
);
  logic modf_q, modf_armed_q;
  logic modf_clear;

  assign modf_clear = ctrl_wr_i && modf_armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modf_q       <= 1'b0;
      modf_armed_q <= 1'b0;
    end else begin
      if (stat_rd_i && modf_q) modf_armed_q <= 1'b1;
      else if (modf_clear)     modf_armed_q <= 1'b0;

      if (ss_conflict_i && modfen_i) modf_q <= 1'b1;
      else if (modf_clear)           modf_q <= 1'b0;
    end
  end

  assign modf_o = modf_q;

  AST_MODF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf_q) |-> $past(modfen_i)); // R6
  AST_MODF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (modf_q && !ctrl_wr_i) |=> modf_q); // R7
endmodule

// File: rtl/rxs_regif.sv
module rxs_regif
  import spi_rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rxfull_i,
  input  logic              ovf_i,
  input  logic              modf_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              modfen_o,
  output logic              stat_rd_o,
  output logic              data_rd_o,
  output logic              ctrl_wr_o
);
  logic rxie_q, errie_q, modfen_q;
  logic stat_wr;

  assign stat_rd_o = reg_rd_i && (reg_addr_i == ADDR_STAT);
  assign data_rd_o = reg_rd_i && (reg_addr_i == ADDR_DATA);
  assign ctrl_wr_o = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign stat_wr   = reg_wr_i && (reg_addr_i == ADDR_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxie_q   <= 1'b0;
      errie_q  <= 1'b0;
      modfen_q <= 1'b0;
    end else begin
      if (ctrl_wr_o) rxie_q <= reg_wdata_i[CB_RXIE];
      if (stat_wr) begin
        errie_q  <= reg_wdata_i[SB_ERRIE];
        modfen_q <= reg_wdata_i[SB_MODFEN];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o[CB_RXIE] = rxie_q;
      ADDR_STAT: begin
        reg_rdata_o[SB_RXFULL] = rxfull_i;
        reg_rdata_o[SB_ERRIE]  = errie_q;
        reg_rdata_o[SB_OVF]    = ovf_i;
        reg_rdata_o[SB_MODF]   = modf_i;
        reg_rdata_o[SB_MODFEN] = modfen_q;
      end
      ADDR_DATA: reg_rdata_o = rx_data_i;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o    = (rxie_q && rxfull_i) || (errie_q && (ovf_i || modf_i));
  assign modfen_o = modfen_q;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (rxie_q || errie_q)); // R8
  AST_ERR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (errie_q && ovf_i) |-> irq_o); // R8
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_first_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              ss_conflict_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] rx_data;
  logic rxfull, ovf, modf, modfen, stat_rd, data_rd, ctrl_wr;

  rxs_data_path #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .cap_first_i(cap_first_i),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
    .stat_rd_i(stat_rd), .data_rd_i(data_rd),
    .rx_data_o(rx_data), .rxfull_o(rxfull), .ovf_o(ovf)
  );

  rxs_fault u_fault (
    .clk(clk), .rst_n(rst_n), .ss_conflict_i(ss_conflict_i),
    .modfen_i(modfen), .stat_rd_i(stat_rd), .ctrl_wr_i(ctrl_wr),
    .modf_o(modf)
  );

  rxs_regif #(.DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr_i),
    .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .rx_data_i(rx_data), .rxfull_i(rxfull), .ovf_i(ovf), .modf_i(modf),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .modfen_o(modfen),
    .stat_rd_o(stat_rd), .data_rd_o(data_rd), .ctrl_wr_o(ctrl_wr)
  );
endmodule

// File: tb/spi_rx_status_bench.sv
module spi_rx_status_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic cap_first, byte_valid, ss_conflict, reg_rd, reg_wr;
  logic [7:0] byte_data, reg_wdata, reg_rdata;
  logic [1:0] reg_addr;
  logic irq;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_rx_status u_spi_rx_status (
    .clk(clk), .rst_n(rst_n), .cap_first_i(cap_first), .byte_valid_i(byte_valid),
    .byte_data_i(byte_data), .ss_conflict_i(ss_conflict), .reg_addr_i(reg_addr),
    .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  // ops: 0 write ctrl, 1 write status, 2 first-bit capture, 3 byte done,
  //      4 read status (expect), 5 read data (expect), 6 check irq (expect)
  localparam int NV = 29;
  localparam logic [14:0] TBL [0:NV-1] = '{
    {3'd1, 8'h40, 4'd8},  // errie on
    {3'd2, 8'h00, 4'd10}, {3'd3, 8'h11, 4'd10},
    {3'd6, 8'h00, 4'd8},  // R8 rx irq off
    {3'd4, 8'hC0, 4'd10}, // R10
    {3'd5, 8'h11, 4'd10},
    {3'd4, 8'h40, 4'd4},  // R4 full cleared
    {3'd2, 8'h00, 4'd10}, {3'd3, 8'h22, 4'd10},
    {3'd4, 8'hC0, 4'd10},
    {3'd2, 8'h00, 4'd1},
    {3'd6, 8'h01, 4'd1},  // R1 ovf before byte end
    {3'd3, 8'h33, 4'd2},
    {3'd5, 8'h22, 4'd2},  // R2 old byte kept
    {3'd6, 8'h01, 4'd4},  // R4 ovf stays after data read
    {3'd2, 8'h00, 4'd3}, {3'd3, 8'h44, 4'd3},
    {3'd4, 8'h60, 4'd3},  // R3 no full
    {3'd5, 8'h22, 4'd3},  // R3 byte 4 lost; R5 clears
    {3'd4, 8'h40, 4'd5},  // R5
    {3'd6, 8'h00, 4'd5},
    {3'd0, 8'h80, 4'd8},
    {3'd6, 8'h00, 4'd8},
    {3'd2, 8'h00, 4'd8}, {3'd3, 8'h55, 4'd8},
    {3'd6, 8'h01, 4'd8},  // R8 rx irq
    {3'd5, 8'h55, 4'd10},
    {3'd6, 8'h00, 4'd8},
    {3'd0, 8'h00, 4'd8}
  };

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input int req);
    reg_addr = a; reg_rd = 1'b1; #1;
    check(req, reg_rdata, exp);
    tick(); reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(); reg_wr = 1'b0;
  endtask

  task automatic run_op(input logic [14:0] v);
    logic [2:0] op; logic [7:0] arg; int req;
    op = v[14:12]; arg = v[11:4]; req = int'(v[3:0]);
    case (op)
      3'd0: wr(2'd0, arg);
      3'd1: wr(2'd1, arg);
      3'd2: begin cap_first = 1'b1; tick(); cap_first = 1'b0; end
      3'd3: begin byte_valid = 1'b1; byte_data = arg; tick(); byte_valid = 1'b0; end
      3'd4: rd(2'd1, arg, req);
      3'd5: rd(2'd2, arg, req);
      default: begin #1; check(req, {7'd0, irq}, arg); end
    endcase
  endtask

  task automatic conflict();
    ss_conflict = 1'b1; tick(); ss_conflict = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cap_first = 0; byte_valid = 0; byte_data = 0; ss_conflict = 0;
    reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) tick();
    rst_n = 1'b1; tick();

    // R9 reset state
    #1; check(9, {7'd0, irq}, 8'h00);
    rd(2'd1, 8'h00, 9); rd(2'd2, 8'h00, 9); rd(2'd0, 8'h00, 9);

    for (int i = 0; i < NV; i++) run_op(TBL[i]);

    // R9 only bits 6 and 2 writable in status; unused reads zero
    wr(2'd1, 8'hFF); rd(2'd1, 8'h44, 9);
    wr(2'd0, 8'hFF); rd(2'd0, 8'h80, 9); rd(2'd3, 8'h00, 9);
    wr(2'd0, 8'h00);

    // R6 conflict ignored with enable off
    wr(2'd1, 8'h40); conflict(); rd(2'd1, 8'h40, 6);
    wr(2'd1, 8'h44); conflict();
    #1; check(8, {7'd0, irq}, 8'h01);   // R8 error irq via mode fault
    // R7 control write without status read keeps flag
    wr(2'd0, 8'h00); rd(2'd1, 8'h54, 7);
    wr(2'd0, 8'h00); rd(2'd1, 8'h44, 7);
    #1; check(7, {7'd0, irq}, 8'h00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule